// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Pin Steering

This block gathers nine event flags held in two 16-bit status words, lets each one be masked, and merges the unmasked ones into a single interrupt request. That request leaves on one of four output pins. A two-bit select input picks the pin. Each pin has its own output-enable, and only the chosen pin is driven. The other pins float.

A polarity input sets the active level of the pin. A mode input chooses between a level request and a one-clock pulse. After reset, all four pins stay floated until a configuration-valid strobe has been seen. This lets a configuration loader finish before the request can reach the board.

Flags are set by one-cycle event pulses. Software clears them by writing ones. The flag words are also brought out so that their contents can be observed.

Top module: `intr_aggregator`

## Requirements
- R1: Status word A holds flags only at bits 14, 12, 11, 10 and 8. Status word B holds flags only at bits 9, 5, 3 and 1. A set pulse on any other bit leaves that bit at 0.
- R2: A clear write with a 1 in an implemented bit clears that flag after the next clock edge. Bits written with 0 keep their value.
- R3: When a set pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R4: A flag whose mask bit is 1 still sets, but it cannot raise the interrupt request.
- R5: In level mode (edge_mode=0), the request is active whenever at least one unmasked flag is set.
- R6: In edge mode (edge_mode=1), the request is active for exactly one clock after the OR of unmasked flags goes from 0 to 1. It then stays inactive while that OR stays 1.
- R7: With active_low=0 an active request drives the pin to 1. With active_low=1 it drives the pin to 0. The inactive level is the inverse.
- R8: Once configured, exactly one pin has its output-enable set: the pin with index pin_sel. Every other pin has oe=0 and value 0.
- R9: From reset until cfg_valid has been seen high at a clock edge, all output-enables are 0. After that the pins stay enabled until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration loaded strobe (sticky once seen) |
| set_a | input | 16 | Event set pulses for status word A |
| set_b | input | 16 | Event set pulses for status word B |
| clr_a_we | input | 1 | Clear write strobe, word A |
| clr_a_data | input | 16 | Write-one-to-clear data, word A |
| clr_b_we | input | 1 | Clear write strobe, word B |
| clr_b_data | input | 16 | Write-one-to-clear data, word B |
| mask_a | input | 16 | Mask bits for word A (1 = suppress) |
| mask_b | input | 16 | Mask bits for word B (1 = suppress) |
| pin_sel | input | 2 | Index of the driven pin |
| active_low | input | 1 | 1 = request is active low |
| edge_mode | input | 1 | 1 = one-clock pulse, 0 = level |
| stat_a | output | 16 | Current flags, word A |
| stat_b | output | 16 | Current flags, word B |
| irq_val | output | 4 | Pin values |
| irq_oe | output | 4 | Pin output-enables |

## Verification
The bench aims at the collision of a set pulse and a clear write on the same flag. A design that gives the clear priority would lose the event and read the flag back as 0. It pulses unimplemented bit positions and expects zeros, which exposes a flag word that keeps stray bits. Edge mode is checked across two consecutive cycles: a design that stretches the pulse would hold the pin active in the second cycle. The bench also switches the select input and the polarity, and drives cfg_valid only after probing the pins. A design that enables pins before configuration, drives unselected pins, or gets the active level backwards would show the wrong enable or value bits.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
   localparam int FLAG_W = 16;
   // implemented flag positions of the two status words
   localparam logic [FLAG_W-1:0] IMPL_A = 16'h5D00;
   localparam logic [FLAG_W-1:0] IMPL_B = 16'h022A;

   typedef struct packed {
      logic              we;
      logic [FLAG_W-1:0] data;
   } clr_wr_t;
endpackage

// File: rtl/intr_flag_reg.sv
module intr_flag_reg
   import intr_agg_pkg::*;
#(
   parameter int                W    = FLAG_W,
   parameter logic [W-1:0]      IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] clr_data_i,
   input  logic [W-1:0] mask_i,
   output logic [W-1:0] flags_o,
   output logic         pend_o
);
   logic [W-1:0] flags_q;
   logic [W-1:0] clr_eff;
   logic [W-1:0] flags_d;

   always_comb begin
      clr_eff = clr_we_i ? clr_data_i : '0;
      // set wins over a simultaneous clear
      flags_d = ((flags_q & ~clr_eff) | set_i) & IMPL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign flags_o = flags_q;
   assign pend_o  = |(flags_q & ~mask_i);
endmodule

// File: rtl/intr_req_gen.sv
module intr_req_gen #(
   parameter bit EDGE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_i,
   input  logic edge_mode_i,
   output logic req_o
);
   generate
      if (EDGE_EN) begin : g_edge
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= pend_i;
         end
         assign req_o = edge_mode_i ? (pend_i & ~pend_q) : pend_i;
      end else begin : g_level
         assign req_o = pend_i;
      end
   endgenerate
endmodule

// File: rtl/intr_pin_steer.sv
module intr_pin_steer #(
   parameter int NPINS = 4,
   localparam int SEL_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
   input  logic             enable_i,
   input  logic             req_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             active_low_i,
   output logic [NPINS-1:0] val_o,
   output logic [NPINS-1:0] oe_o
);
   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         logic hit;
         assign hit      = enable_i && (sel_i == SEL_W'(p));
         assign oe_o[p]  = hit;
         assign val_o[p] = hit & (req_i ^ active_low_i);
      end
   endgenerate
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
   import intr_agg_pkg::*;
#(
   parameter int NPINS   = 4,
   parameter bit EDGE_EN = 1'b1,
   localparam int SEL_W  = $clog2(NPINS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic [FLAG_W-1:0] set_a,
   input  logic [FLAG_W-1:0] set_b,
   input  logic              clr_a_we,
   input  logic [FLAG_W-1:0] clr_a_data,
   input  logic              clr_b_we,
   input  logic [FLAG_W-1:0] clr_b_data,
   input  logic [FLAG_W-1:0] mask_a,
   input  logic [FLAG_W-1:0] mask_b,
   input  logic [SEL_W-1:0]  pin_sel,
   input  logic              active_low,
   input  logic              edge_mode,
   output logic [FLAG_W-1:0] stat_a,
   output logic [FLAG_W-1:0] stat_b,
   output logic [NPINS-1:0]  irq_val,
   output logic [NPINS-1:0]  irq_oe
);
   generate
      if (NPINS < 2 || (NPINS & (NPINS - 1)) != 0) begin : g_bad_npins
         $error("NPINS must be a power of two of at least 2");
      end
   endgenerate

   clr_wr_t clr_a, clr_b;
   logic    pend_a, pend_b, req, cfg_done_q;

   assign clr_a = '{we: clr_a_we, data: clr_a_data};
   assign clr_b = '{we: clr_b_we, data: clr_b_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_done_q <= 1'b0;
      else if (cfg_valid) cfg_done_q <= 1'b1;
   end

   intr_flag_reg #(.W(FLAG_W), .IMPL(IMPL_A)) u_word_a (
      .clk(clk), .rst_n(rst_n), .set_i(set_a), .clr_we_i(clr_a.we),
      .clr_data_i(clr_a.data), .mask_i(mask_a), .flags_o(stat_a), .pend_o(pend_a)
   );

   intr_flag_reg #(.W(FLAG_W), .IMPL(IMPL_B)) u_word_b (
      .clk(clk), .rst_n(rst_n), .set_i(set_b), .clr_we_i(clr_b.we),
      .clr_data_i(clr_b.data), .mask_i(mask_b), .flags_o(stat_b), .pend_o(pend_b)
   );

   intr_req_gen #(.EDGE_EN(EDGE_EN)) u_req (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_a | pend_b),
      .edge_mode_i(edge_mode), .req_o(req)
   );

   intr_pin_steer #(.NPINS(NPINS)) u_steer (
      .enable_i(cfg_done_q), .req_i(req), .sel_i(pin_sel),
      .active_low_i(active_low), .val_o(irq_val), .oe_o(irq_oe)
   );
endmodule

// File: rtl/intr_aggregator_chk.sv
module intr_aggregator_chk
   import intr_agg_pkg::*;
#(
   parameter int NPINS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_valid,
   input logic [FLAG_W-1:0] set_a,
   input logic [FLAG_W-1:0] set_b,
   input logic [FLAG_W-1:0] mask_a,
   input logic [FLAG_W-1:0] mask_b,
   input logic              edge_mode,
   input logic [FLAG_W-1:0] stat_a,
   input logic [FLAG_W-1:0] stat_b,
   input logic [NPINS-1:0]  irq_oe,
   input logic              req
);
   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_q <= 1'b0;
      else if (cfg_valid) seen_q <= 1'b1;
   end

   // R1
   no_stray_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_a & ~IMPL_A) == '0) && ((stat_b & ~IMPL_B) == '0));

   // R3
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_a & IMPL_A)) |=> ((stat_a & $past(set_a & IMPL_A)) == $past(set_a & IMPL_A)));

   // R4
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode && ((stat_a & ~mask_a) == '0) && ((stat_b & ~mask_b) == '0)) |-> !req);

   // R6
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && req) |=> !(edge_mode && req));

   // R8
   one_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_oe));

   // R9
   float_until_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> (irq_oe == '0));
endmodule

bind intr_aggregator intr_aggregator_chk #(.NPINS(NPINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .set_a(set_a), .set_b(set_b),
   .mask_a(mask_a), .mask_b(mask_b), .edge_mode(edge_mode), .stat_a(stat_a),
   .stat_b(stat_b), .irq_oe(irq_oe), .req(req)
);

// File: tb/intr_aggregator_tb.sv
module intr_aggregator_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_valid = 0;
   logic [15:0] set_a = 0, set_b = 0, clr_a_data = 0, clr_b_data = 0;
   logic [15:0] mask_a = 0, mask_b = 0;
   logic        clr_a_we = 0, clr_b_we = 0;
   logic [1:0]  pin_sel = 0;
   logic        active_low = 0, edge_mode = 0;
   logic [15:0] stat_a, stat_b;
   logic [3:0]  irq_val, irq_oe;
   int          errs = 0, checks = 0;

   always #10 clk = ~clk;

   intr_aggregator u_dut (.*);

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pins(logic act);
      logic [3:0] oe = 4'b0001 << pin_sel;
      logic [3:0] v  = (act ^ active_low) ? oe : 4'b0000;
      return {oe, v};
   endfunction

   task automatic t_reset_gate();
      tick();
      chk("R9 reset oe", irq_oe, 0);
      chk("R1 reset flags", {stat_a, stat_b}, 0);
      set_a = 16'h4000; tick(); set_a = 0;
      chk("R9 no cfg yet", irq_oe, 0);
      cfg_valid = 1; tick(); cfg_valid = 0; tick();
      chk("R9 sticky enable", {irq_oe, irq_val}, pins(1));
      clr_a_we = 1; clr_a_data = 16'hFFFF; tick(); clr_a_we = 0;
   endtask

   task automatic t_positions();
      set_a = 16'hFFFF; set_b = 16'hFFFF; tick(); set_a = 0; set_b = 0;
      chk("R1 word A bits", stat_a, 32'h5D00);
      chk("R1 word B bits", stat_b, 32'h022A);
   endtask

   task automatic t_clear();
      clr_a_we = 1; clr_a_data = 16'h1400; tick(); clr_a_we = 0;
      chk("R2 partial clear A", stat_a, 32'h4900);
      clr_a_data = 16'hFFFF; tick();
      chk("R2 data without strobe", stat_a, 32'h4900);
      clr_a_we = 1; clr_b_we = 1; clr_b_data = 16'hFFFF; tick();
      clr_a_we = 0; clr_b_we = 0;
      chk("R2 full clear", {stat_a, stat_b}, 0);
   endtask

   task automatic t_priority();
      set_b = 16'h0008; clr_b_we = 1; clr_b_data = 16'h0008; tick();
      set_b = 0; clr_b_we = 0;
      chk("R3 set beats clear", stat_b, 32'h0008);
      clr_b_we = 1; tick(); clr_b_we = 0;
      chk("R3 later clear", stat_b, 0);
   endtask

   task automatic t_mask_level();
      edge_mode = 0; mask_b = 16'h0002;
      set_b = 16'h0002; tick(); set_b = 0;
      chk("R4 masked flag sets", stat_b, 32'h0002);
      chk("R4 masked no irq", {irq_oe, irq_val}, pins(0));
      mask_b = 0; #1;
      chk("R5 unmask raises level", {irq_oe, irq_val}, pins(1));
      tick();
      chk("R5 level holds", {irq_oe, irq_val}, pins(1));
      clr_b_we = 1; clr_b_data = 16'h0002; tick(); clr_b_we = 0;
      chk("R5 drops after clear", {irq_oe, irq_val}, pins(0));
   endtask

   task automatic t_edge();
      edge_mode = 1;
      set_a = 16'h0100; tick(); set_a = 0;
      chk("R6 pulse cycle", {irq_oe, irq_val}, pins(1));
      tick();
      chk("R6 pulse ends", {irq_oe, irq_val}, pins(0));
      set_a = 16'h0400; tick(); set_a = 0;
      chk("R6 no retrigger while pending", {irq_oe, irq_val}, pins(0));
      clr_a_we = 1; clr_a_data = 16'hFFFF; tick(); clr_a_we = 0; tick();
      edge_mode = 0;
   endtask

   task automatic t_polarity_steer();
      active_low = 1; #1;
      chk("R7 idle high when active-low", {irq_oe, irq_val}, 8'h11);
      set_a = 16'h0800; tick(); set_a = 0;
      chk("R7 active-low asserted", {irq_oe, irq_val}, 8'h10);
      active_low = 0; pin_sel = 2; #1;
      chk("R8 steer to pin 2", {irq_oe, irq_val}, 8'h44);
      pin_sel = 3; #1;
      chk("R8 steer to pin 3", {irq_oe, irq_val}, 8'h88);
   endtask

   initial begin
      fork
         begin
            repeat (3) tick();
            rst_n = 1;
            t_reset_gate();
            t_positions();
            t_clear();
            t_priority();
            t_mask_level();
            t_edge();
            t_polarity_steer();
         end
         begin
            repeat (5000) @(posedge clk);
            errs++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule